// File: doc/BRIEF.md
# VBUS Drive Supervisor with Rise-Time Watchdog

This block runs the external VBUS power switch of an On-The-Go A-device and checks that the bus voltage actually comes up once drive is requested. Software controls two bits. A bus-request bit turns VBUS drive on and off. A drop control turns drive off and clears the request. The block drives the switch enable pin at a level set by an enable-polarity input. It watches the switch's status pin through a second polarity input, and the VBUS-valid comparator output, which arrives as a digital level.

When drive starts, a cycle counter begins. If VBUS does not become good before the programmable limit, the block latches an overcurrent status, emits a one-cycle error event and forces the switch off. VBUS is good when the comparator reports valid and the switch reports good. The latched error holds until software pulses the error-clear input. Both pin inputs are resynchronised to the block clock before use.

Top module: `vbus_supervisor`

## Requirements
- R1: `sw_en_o` equals the internal drive state XOR `en_pol_i`. Drive on with polarity 0 gives 1, and drive on with polarity 1 gives 0. After reset the drive state, `bus_req_o`, `overcur_o` and `vbus_err_o` are all 0.
- R2: The switch counts as good when the synchronised `sw_stat_i` differs from `stat_pol_i`: pin 1 with polarity 0, or pin 0 with polarity 1. VBUS counts as up only when the switch is good and the synchronised `vbus_vld_i` is 1.
- R3: A clock edge with `req_wr_i` high and `drop_i` low loads `req_wdata_i` into `bus_req_o`. Drive switches on or off on that same edge, unless an error is latched.
- R4: A clock edge with `drop_i` high clears `bus_req_o` and turns drive off, even if a request write arrives in the same cycle.
- R5: `TIMEOUT_CYC` edges after drive turns on, if VBUS has not been up in any earlier cycle of that drive period, `overcur_o` rises. `vbus_err_o` is high for the cycle that follows that same edge.
- R6: `vbus_err_o` is never high for two consecutive cycles.
- R7: While `overcur_o` is 1, `sw_en_o` sits at its inactive level (`en_pol_i`), and `bus_req_o` keeps its value.
- R8: `overcur_o` stays set until an edge with `err_clr_i` high. That edge clears it, and drive resumes on the same edge if `bus_req_o` is still 1.
- R9: The timeout counter restarts from zero whenever drive is off. Once VBUS is seen up during a drive period, no error is raised for the rest of that period.
- R10: The status and VBUS-valid pins pass through `SYNC_STAGES` flops. With two stages, a pin level present before edge N is first used for the decision of edge N+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_wr_i | input | 1 | Write strobe for the bus-request bit |
| req_wdata_i | input | 1 | Value written to the bus-request bit |
| drop_i | input | 1 | VBUS drop control, forces drive off and clears the request |
| err_clr_i | input | 1 | Write-one pulse clearing the latched VBUS error |
| en_pol_i | input | 1 | Enable pin polarity: 0 active high, 1 active low |
| stat_pol_i | input | 1 | Status pin polarity: 0 active high, 1 active low |
| sw_stat_i | input | 1 | Raw status pin from the external power switch |
| vbus_vld_i | input | 1 | Raw VBUS-valid comparator output |
| sw_en_o | output | 1 | Enable pin to the external power switch |
| bus_req_o | output | 1 | Current bus-request bit |
| overcur_o | output | 1 | Latched overcurrent / VBUS error status |
| vbus_err_o | output | 1 | One-cycle event when the error is latched |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 20 and `SYNC_STAGES` = 2. This puts the expiry edge within a few dozen cycles, so the bench can check the exact edge on which the error latches and a restart of the count after a short drive period. With two synchroniser stages the latency is small and known. The bench places a valid level one cycle before and one cycle after the last moment that still prevents the error.

// File: rtl/vbus_sup_pkg.sv
package vbus_sup_pkg;

    // Control state of the supervisor top
    typedef struct packed {
        logic bus_req;   // software bus request
        logic drive;     // VBUS drive currently on
        logic err;       // latched rise-time failure
        logic evt;       // one-cycle error event
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '0;

endpackage

// File: rtl/vbus_sup_sync.sv
module vbus_sup_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/vbus_sup_rise_timer.sv
module vbus_sup_rise_timer #(
    parameter int TIMEOUT_CYC = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,       // drive is on
    input  logic vld_i,       // synchronised comparator level
    input  logic stat_i,      // synchronised switch status pin
    input  logic stat_pol_i,  // 1: status pin active low
    output logic expire_o     // limit reached without VBUS up
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       up;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        up       = vld_i & (stat_i ^ stat_pol_i);
        if (!run_i) begin
            st_d = '0;
        end else if (!st_q.seen) begin
            if (up) begin
                st_d.seen = 1'b1;
            end else if (st_q.cnt == LAST) begin
                expire_o = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/vbus_supervisor.sv
module vbus_supervisor
    import vbus_sup_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr_i,
    input  logic req_wdata_i,
    input  logic drop_i,
    input  logic err_clr_i,
    input  logic en_pol_i,
    input  logic stat_pol_i,
    input  logic sw_stat_i,
    input  logic vbus_vld_i,
    output logic sw_en_o,
    output logic bus_req_o,
    output logic overcur_o,
    output logic vbus_err_o
);

    localparam int PIN_W = 2;

    ctl_state_t       s_d, s_q;
    logic [PIN_W-1:0] pins_s;
    logic             expire;

    vbus_sup_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sw_stat_i, vbus_vld_i}),
        .q_o   (pins_s)
    );

    vbus_sup_rise_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (s_q.drive),
        .vld_i      (pins_s[0]),
        .stat_i     (pins_s[1]),
        .stat_pol_i (stat_pol_i),
        .expire_o   (expire)
    );

    always_comb begin
        s_d     = s_q;
        s_d.evt = 1'b0;
        // drop has priority over a request write
        if (drop_i) begin
            s_d.bus_req = 1'b0;
        end else if (req_wr_i) begin
            s_d.bus_req = req_wdata_i;
        end
        // error latch: only the clear pulse leaves it
        if (s_q.err) begin
            if (err_clr_i) begin
                s_d.err = 1'b0;
            end
        end else if (expire) begin
            s_d.err = 1'b1;
            s_d.evt = 1'b1;
        end
        s_d.drive = s_d.bus_req & ~s_d.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= CTL_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign sw_en_o    = s_q.drive ^ en_pol_i;
    assign bus_req_o  = s_q.bus_req;
    assign overcur_o  = s_q.err;
    assign vbus_err_o = s_q.evt;

endmodule

// File: rtl/vbus_sup_chk.sv
module vbus_sup_chk (
    input logic clk,
    input logic rst_n,
    input logic req_wr_i,
    input logic req_wdata_i,
    input logic drop_i,
    input logic err_clr_i,
    input logic en_pol_i,
    input logic sw_en_o,
    input logic bus_req_o,
    input logic overcur_o,
    input logic vbus_err_o
);

    // R3: a write without drop lands on the next edge
    p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr_i && !drop_i) |=> (bus_req_o == $past(req_wdata_i)));

    // R4: drop clears the request and turns drive off
    p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drop_i |=> (!bus_req_o && (sw_en_o == en_pol_i)));

    // R5: latching the error comes with the event
    p_evt_on_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overcur_o) |-> vbus_err_o);

    // R6: event lasts one cycle
    p_evt_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vbus_err_o |=> !vbus_err_o);

    // R7: switch held inactive while error is latched
    p_err_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overcur_o |-> (sw_en_o == en_pol_i));

    // R8: error holds without a clear
    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overcur_o && !err_clr_i) |=> overcur_o);

    // R8: clear pulse removes the error
    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overcur_o && err_clr_i) |=> !overcur_o);

endmodule

bind vbus_supervisor vbus_sup_chk i_chk (.*);

// File: tb/test_vbus_supervisor.sv
module test_vbus_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int T          = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_wr_i = 1'b0, req_wdata_i = 1'b0, drop_i = 1'b0, err_clr_i = 1'b0;
    logic en_pol_i = 1'b0, stat_pol_i = 1'b0, sw_stat_i = 1'b0, vbus_vld_i = 1'b0;
    logic sw_en_o, bus_req_o, overcur_o, vbus_err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbus_supervisor #(
        .TIMEOUT_CYC (T),
        .SYNC_STAGES (2)
    ) i_vbus_supervisor (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_wr_i    (req_wr_i),
        .req_wdata_i (req_wdata_i),
        .drop_i      (drop_i),
        .err_clr_i   (err_clr_i),
        .en_pol_i    (en_pol_i),
        .stat_pol_i  (stat_pol_i),
        .sw_stat_i   (sw_stat_i),
        .vbus_vld_i  (vbus_vld_i),
        .sw_en_o     (sw_en_o),
        .bus_req_o   (bus_req_o),
        .overcur_o   (overcur_o),
        .vbus_err_o  (vbus_err_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_req(input logic v);
        req_wr_i    = 1'b1;
        req_wdata_i = v;
        @(negedge clk);
        req_wr_i    = 1'b0;
    endtask

    task automatic cleanup();
        write_req(1'b0);
        vbus_vld_i = 1'b0;
        sw_stat_i  = 1'b0;
        stat_pol_i = 1'b0;
        en_pol_i   = 1'b0;
        err_clr_i  = 1'b1;
        tick(1);
        err_clr_i  = 1'b0;
        tick(4);
    endtask

    task automatic t_reset();
        check("R1 reset sw_en", sw_en_o, 1'b0);
        check("R1 reset bus_req", bus_req_o, 1'b0);
        check("R1 reset overcur", overcur_o, 1'b0);
        check("R1 reset event", vbus_err_o, 1'b0);
        en_pol_i = 1'b1;
        tick(1);
        check("R1 idle active-low enable", sw_en_o, 1'b1);
        en_pol_i = 1'b0;
        tick(1);
    endtask

    task automatic t_normal_up();
        sw_stat_i  = 1'b1;
        vbus_vld_i = 1'b1;
        tick(3);
        write_req(1'b1);
        check("R3 request sets", bus_req_o, 1'b1);
        check("R3 drive on", sw_en_o, 1'b1);
        tick(3 * T);
        check("R9 no error after VBUS up", overcur_o, 1'b0);
        check("R9 drive stays on", sw_en_o, 1'b1);
        write_req(1'b0);
        check("R3 request clears drive", sw_en_o, 1'b0);
        cleanup();
    endtask

    task automatic t_drop();
        write_req(1'b1);
        drop_i      = 1'b1;
        req_wr_i    = 1'b1;
        req_wdata_i = 1'b1;
        tick(1);
        req_wr_i = 1'b0;
        drop_i   = 1'b0;
        check("R4 drop clears request over write", bus_req_o, 1'b0);
        check("R4 drop turns drive off", sw_en_o, 1'b0);
        tick(2);
        check("R4 request stays clear", bus_req_o, 1'b0);
        cleanup();
    endtask

    task automatic t_timeout();
        write_req(1'b1);
        tick(T - 1);
        check("R5 no error before limit", overcur_o, 1'b0);
        tick(1);
        check("R5 error latched at limit", overcur_o, 1'b1);
        check("R5 event at latch", vbus_err_o, 1'b1);
        check("R7 switch forced off", sw_en_o, 1'b0);
        tick(1);
        check("R6 event single cycle", vbus_err_o, 1'b0);
        tick(10);
        check("R8 error held", overcur_o, 1'b1);
        check("R7 request retained", bus_req_o, 1'b1);
        check("R7 switch still off", sw_en_o, 1'b0);
        sw_stat_i  = 1'b1;
        vbus_vld_i = 1'b1;
        tick(3);
        err_clr_i = 1'b1;
        tick(1);
        err_clr_i = 1'b0;
        check("R8 clear removes error", overcur_o, 1'b0);
        check("R8 drive resumes", sw_en_o, 1'b1);
        tick(2 * T);
        check("R8 no new error with VBUS up", overcur_o, 1'b0);
        cleanup();
    endtask

    task automatic t_polarity();
        stat_pol_i = 1'b1;
        sw_stat_i  = 1'b0;
        vbus_vld_i = 1'b1;
        en_pol_i   = 1'b1;
        tick(3);
        write_req(1'b1);
        check("R1 active-low enable driven", sw_en_o, 1'b0);
        tick(2 * T);
        check("R2 active-low status accepted", overcur_o, 1'b0);
        write_req(1'b0);
        check("R1 active-low enable released", sw_en_o, 1'b1);
        sw_stat_i = 1'b1;
        tick(3);
        write_req(1'b1);
        tick(T);
        check("R2 inactive status gives error", overcur_o, 1'b1);
        check("R7 active-low switch held off", sw_en_o, 1'b1);
        cleanup();
    endtask

    task automatic t_restart();
        write_req(1'b1);
        tick(T - 6);
        write_req(1'b0);
        tick(1);
        write_req(1'b1);
        tick(T - 1);
        check("R9 count restarted", overcur_o, 1'b0);
        tick(1);
        check("R9 full window after restart", overcur_o, 1'b1);
        cleanup();
    endtask

    task automatic t_sync_edge();
        sw_stat_i = 1'b1;
        tick(3);
        write_req(1'b1);
        tick(T - 3);
        vbus_vld_i = 1'b1;
        tick(3);
        check("R10 valid just in time", overcur_o, 1'b0);
        cleanup();
        sw_stat_i = 1'b1;
        tick(3);
        write_req(1'b1);
        tick(T - 2);
        vbus_vld_i = 1'b1;
        tick(2);
        check("R10 valid one cycle late", overcur_o, 1'b1);
        cleanup();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_normal_up();
        t_drop();
        t_timeout();
        t_polarity();
        t_restart();
        t_sync_edge();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule